// File: doc/BRIEF.md
# Dual-CPU Status Mailbox

This block is a small shared status register that lets a host processor and a coprocessor exchange a 16-bit status word and tell each other that a new value is waiting. Each side can write the status word. A flag word records the direction of the last unread write. Bit 0 means "the coprocessor wrote, the host has not yet looked". Bit 1 means "the host wrote, the coprocessor has not yet looked". A write from one side sets its own bit. A read of the flag word by the other side clears that bit again.

The host reaches the block through a two-bit offset. Offsets 0 and 1 both map to the status word, and offset 2 maps to the flag word. The coprocessor has a one-bit port select: 0 selects the status word and 1 selects the flag word. The coprocessor may also overwrite the whole flag word. Both read paths are registered. Read data appears in the cycle after the read strobe and holds until the next read on that side. Reset is synchronous and active high.

Top module: `status_mailbox`

## Requirements
- R1: A cycle with `rst` high clears the status word, the flag word and both read-data outputs to zero.
- R2: A host write (`host_wr`) at offset 0 or offset 1 loads `host_wdata` into the status word and sets flag bit 1.
- R3: A host read at offset 0 or offset 1 returns the status word and changes neither the status word nor the flag word.
- R4: A host read at offset 2 returns the flag word as it was before the read, then clears flag bit 0.
- R5: A coprocessor write with `cp_port` = 0 loads `cp_wdata` into the status word and sets flag bit 0.
- R6: A coprocessor read with `cp_port` = 1 returns the flag word as it was before the read, then clears flag bit 1.
- R7: A coprocessor write with `cp_port` = 1 loads all bits of `cp_wdata` into the flag word.
- R8: A coprocessor read with `cp_port` = 0 returns the status word and has no side effect.
- R9: When a set and a clear of the same flag bit fall in the same cycle, the bit ends up set.
- R10: A host read at offset 3 returns zero. A host write at offset 3 changes neither the status word nor the flag word.
- R11: When both sides write the status word in the same cycle, the host value is kept and both flag bits 0 and 1 are set.
- R12: Read data is registered. It appears on `host_rdata` or `cp_rdata` one cycle after the read strobe and holds until the next read on that side.
- R13: A coprocessor flag-word load overrides any same-cycle flag clear. Same-cycle sets are ORed into the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_off | input | OFF_W | Host register offset |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered host read data |
| cp_wr | input | 1 | Coprocessor write strobe |
| cp_rd | input | 1 | Coprocessor read strobe |
| cp_port | input | 1 | Coprocessor port select: 0 status, 1 flags |
| cp_wdata | input | DATA_W | Coprocessor write data |
| cp_rdata | output | DATA_W | Registered coprocessor read data |

## Verification
The flag word can only be seen through the reads that also clear it. A wrong set or clear therefore shows up in the very next flag read on either side. It then also distorts every later flag read, because a missing clear leaves a stale bit and a missing set hides a new message.

A status word loaded from the wrong side, or not loaded at all, shows on the next status read, one cycle after the strobe. The bench drives same-cycle collisions on purpose: write against write, set against clear, and load against clear. Errors in priority only appear in those cycles.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  // Flag word bit positions; the direction meaning is part of the protocol
  localparam int FLG_CP_WROTE   = 0;  // set by coprocessor status write
  localparam int FLG_HOST_WROTE = 1;  // set by host status write

  // Host offsets
  localparam int HOST_OFF_STAT_A = 0;
  localparam int HOST_OFF_STAT_B = 1;
  localparam int HOST_OFF_FLAGS  = 2;

  // Coprocessor port select
  typedef enum logic {
    CP_PORT_STATUS = 1'b0,
    CP_PORT_FLAGS  = 1'b1
  } cp_port_e;

  // Per-side flag request bundle
  typedef struct packed {
    logic set_bit;
    logic clr_bit;
  } flag_req_t;
endpackage

// File: rtl/mbx_host_port.sv
`timescale 1ns/1ps
module mbx_host_port
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] flags,
  output logic              status_load,
  output logic              flag_set,   // host wrote status
  output logic              flag_clr,   // host consumed coprocessor message
  output logic [DATA_W-1:0] rdata
);
  localparam logic [OFF_W-1:0] OFF_A = OFF_W'(HOST_OFF_STAT_A);
  localparam logic [OFF_W-1:0] OFF_B = OFF_W'(HOST_OFF_STAT_B);
  localparam logic [OFF_W-1:0] OFF_F = OFF_W'(HOST_OFF_FLAGS);

  logic hit_status;
  logic hit_flags;

  always_comb begin
    hit_status = (off == OFF_A) || (off == OFF_B);
    hit_flags  = (off == OFF_F);
  end

  always_comb begin
    status_load = wr && hit_status;
    flag_set    = wr && hit_status;
    flag_clr    = rd && hit_flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      if (hit_status)     rdata <= status;
      else if (hit_flags) rdata <= flags;
      else                rdata <= '0;
    end
  end
endmodule

// File: rtl/mbx_cop_port.sv
`timescale 1ns/1ps
module mbx_cop_port
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic              port,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] flags,
  output logic              status_load,
  output logic              flags_load,
  output logic              flag_set,   // coprocessor wrote status
  output logic              flag_clr,   // coprocessor consumed host message
  output logic [DATA_W-1:0] rdata
);
  cp_port_e sel;

  always_comb begin
    sel         = cp_port_e'(port);
    status_load = wr && (sel == CP_PORT_STATUS);
    flag_set    = wr && (sel == CP_PORT_STATUS);
    flags_load  = wr && (sel == CP_PORT_FLAGS);
    flag_clr    = rd && (sel == CP_PORT_FLAGS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= (sel == CP_PORT_FLAGS) ? flags : status;
    end
  end
endmodule

// File: rtl/mbx_regs.sv
`timescale 1ns/1ps
module mbx_regs
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_load,
  input  logic [DATA_W-1:0] host_data,
  input  logic              cp_load,
  input  logic [DATA_W-1:0] cp_data,
  input  flag_req_t         host_req,   // acts on FLG_HOST_WROTE / FLG_CP_WROTE
  input  flag_req_t         cp_req,
  input  logic              flags_load,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] flags
);
  logic [DATA_W-1:0] set_mask;
  logic [DATA_W-1:0] clr_mask;
  logic [DATA_W-1:0] flags_nx;
  logic [DATA_W-1:0] status_nx;

  // Set and clear masks per flag bit
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    set_mask[FLG_HOST_WROTE] = host_req.set_bit;
    set_mask[FLG_CP_WROTE]   = cp_req.set_bit;
    clr_mask[FLG_CP_WROTE]   = host_req.clr_bit;
    clr_mask[FLG_HOST_WROTE] = cp_req.clr_bit;
  end

  // Per-bit next state: load beats clear, set beats everything
  for (genvar b = 0; b < DATA_W; b++) begin : g_flag
    always_comb begin
      if (flags_load)       flags_nx[b] = cp_data[b];
      else if (clr_mask[b]) flags_nx[b] = 1'b0;
      else                  flags_nx[b] = flags[b];
      if (set_mask[b])      flags_nx[b] = 1'b1;
    end
  end

  // Host wins a same-cycle status collision
  always_comb begin
    if (host_load)    status_nx = host_data;
    else if (cp_load) status_nx = cp_data;
    else              status_nx = status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      flags  <= '0;
    end else begin
      status <= status_nx;
      flags  <= flags_nx;
    end
  end
endmodule

// File: rtl/status_mailbox.sv
`timescale 1ns/1ps
module status_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [OFF_W-1:0]  host_off,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              cp_wr,
  input  logic              cp_rd,
  input  logic              cp_port,
  input  logic [DATA_W-1:0] cp_wdata,
  output logic [DATA_W-1:0] cp_rdata
);
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] flags_q;
  logic              h_load, h_set, h_clr;
  logic              c_load, c_fload, c_set, c_clr;
  flag_req_t         h_req, c_req;

  mbx_host_port #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_host (
    .clk(clk), .rst(rst), .wr(host_wr), .rd(host_rd), .off(host_off),
    .status(status_q), .flags(flags_q),
    .status_load(h_load), .flag_set(h_set), .flag_clr(h_clr),
    .rdata(host_rdata)
  );

  mbx_cop_port #(.DATA_W(DATA_W)) u_cop (
    .clk(clk), .rst(rst), .wr(cp_wr), .rd(cp_rd), .port(cp_port),
    .status(status_q), .flags(flags_q),
    .status_load(c_load), .flags_load(c_fload),
    .flag_set(c_set), .flag_clr(c_clr),
    .rdata(cp_rdata)
  );

  always_comb begin
    h_req.set_bit = h_set;
    h_req.clr_bit = h_clr;
    c_req.set_bit = c_set;
    c_req.clr_bit = c_clr;
  end

  mbx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .host_load(h_load), .host_data(host_wdata),
    .cp_load(c_load), .cp_data(cp_wdata),
    .host_req(h_req), .cp_req(c_req),
    .flags_load(c_fload),
    .status(status_q), .flags(flags_q)
  );
endmodule

// File: rtl/status_mailbox_chk.sv
`timescale 1ns/1ps
module status_mailbox_chk #(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic              host_rd,
  input logic [OFF_W-1:0]  host_off,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              cp_wr,
  input logic              cp_rd,
  input logic              cp_port,
  input logic [DATA_W-1:0] cp_wdata,
  input logic [DATA_W-1:0] cp_rdata,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] flags_q
);
  logic h_map_wr;
  always_comb h_map_wr = host_wr && (host_off < OFF_W'(2));

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (status_q == '0 && flags_q == '0 && host_rdata == '0 && cp_rdata == '0));

  // R2
  host_write_sets_chk: assert property (@(posedge clk) disable iff (rst)
    h_map_wr |=> (status_q == $past(host_wdata) && flags_q[1]));

  // R4
  host_flag_read_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_off == OFF_W'(2) && !cp_wr)
      |=> (host_rdata == $past(flags_q) && !flags_q[0]));

  // R5
  cp_status_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_wr && !cp_port && !h_map_wr) |=> (status_q == $past(cp_wdata) && flags_q[0]));

  // R6
  cp_flag_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_rd && cp_port && !cp_wr && !h_map_wr)
      |=> (cp_rdata == $past(flags_q) && !flags_q[1]));

  // R8
  cp_status_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cp_rd && !cp_port) |=> (cp_rdata == $past(status_q)));

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (h_map_wr && cp_rd && cp_port) |=> flags_q[1]);

  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_off == OFF_W'(3)) |=> (host_rdata == '0));

  // R12
  host_rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
endmodule

bind status_mailbox status_mailbox_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst),
  .host_wr(host_wr), .host_rd(host_rd), .host_off(host_off),
  .host_wdata(host_wdata), .host_rdata(host_rdata),
  .cp_wr(cp_wr), .cp_rd(cp_rd), .cp_port(cp_port),
  .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
  .status_q(status_q), .flags_q(flags_q)
);

// File: tb/test_status_mailbox.sv
`timescale 1ns/1ps
module test_status_mailbox;
  localparam int DW = 16;
  localparam int NV = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 0, host_rd = 0;
  logic [1:0]    host_off = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          cp_wr = 0, cp_rd = 0, cp_port = 0;
  logic [DW-1:0] cp_wdata = '0;
  logic [DW-1:0] cp_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  status_mailbox #(.DATA_W(DW), .OFF_W(2)) i_status_mailbox (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_rd(host_rd), .host_off(host_off),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cp_wr(cp_wr), .cp_rd(cp_rd), .cp_port(cp_port),
    .cp_wdata(cp_wdata), .cp_rdata(cp_rdata)
  );

  // {check, side(0 host,1 cp), wr, rd, addr[1:0], wdata, expected rdata}
  localparam logic [37:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b1,2'd2,16'h0000,16'h0000}, // R1 flags zero after reset
    {1'b0,1'b0,1'b1,1'b0,2'd0,16'h1234,16'h0000}, // R2 host write off0
    {1'b1,1'b0,1'b0,1'b1,2'd0,16'h0000,16'h1234}, // R3
    {1'b1,1'b0,1'b0,1'b1,2'd1,16'h0000,16'h1234}, // R3 alias
    {1'b1,1'b1,1'b0,1'b1,2'd0,16'h0000,16'h1234}, // R8
    {1'b1,1'b1,1'b0,1'b1,2'd1,16'h0000,16'h0002}, // R6 sees bit1 (R2)
    {1'b1,1'b1,1'b0,1'b1,2'd1,16'h0000,16'h0000}, // R6 bit1 cleared
    {1'b0,1'b1,1'b1,1'b0,2'd0,16'hABCD,16'h0000}, // R5
    {1'b1,1'b0,1'b0,1'b1,2'd0,16'h0000,16'hABCD}, // R5 status
    {1'b1,1'b0,1'b0,1'b1,2'd2,16'h0000,16'h0001}, // R4 / R5 bit0
    {1'b1,1'b0,1'b0,1'b1,2'd2,16'h0000,16'h0000}, // R4 bit0 cleared
    {1'b0,1'b1,1'b1,1'b0,2'd1,16'hF0F3,16'h0000}, // R7 load
    {1'b1,1'b0,1'b0,1'b1,2'd2,16'h0000,16'hF0F3}, // R7 / R4
    {1'b1,1'b1,1'b0,1'b1,2'd1,16'h0000,16'hF0F2}, // R6
    {1'b0,1'b0,1'b1,1'b0,2'd1,16'h5A5A,16'h0000}, // R2 write off1
    {1'b0,1'b0,1'b1,1'b0,2'd3,16'hFFFF,16'h0000}, // R10 ignored write
    {1'b1,1'b0,1'b0,1'b1,2'd3,16'h0000,16'h0000}, // R10 zero read
    {1'b1,1'b0,1'b0,1'b1,2'd0,16'h0000,16'h5A5A}, // R10 status kept
    {1'b1,1'b1,1'b0,1'b1,2'd1,16'h0000,16'hF0F2}  // R10 flags kept
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle with both sides driven; results sampled at the next negedge
  task automatic cyc(input logic hw, input logic hr, input logic [1:0] ha, input logic [DW-1:0] hd,
                     input logic cw, input logic cr, input logic cp, input logic [DW-1:0] cd);
    host_wr = hw; host_rd = hr; host_off = ha; host_wdata = hd;
    cp_wr = cw; cp_rd = cr; cp_port = cp; cp_wdata = cd;
    @(posedge clk);
    @(negedge clk);
    host_wr = 0; host_rd = 0; cp_wr = 0; cp_rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 host_rdata", host_rdata, 16'h0000);
    chk("R1 cp_rdata", cp_rdata, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      if (v[36]) cyc(1'b0, 1'b0, 2'd0, 16'h0, v[35], v[34], v[32], v[31:16]);
      else       cyc(v[35], v[34], v[33:32], v[31:16], 1'b0, 1'b0, 1'b0, 16'h0);
      if (v[37]) chk($sformatf("vec%0d", i), v[36] ? cp_rdata : host_rdata, v[15:0]);
    end
    // flags now F0F0, status 5A5A

    // R9: host sets bit1 while coprocessor clears it
    cyc(1'b1, 1'b0, 2'd0, 16'h7777, 1'b0, 1'b1, 1'b1, 16'h0);
    chk("R9 cp pre-read", cp_rdata, 16'hF0F0);
    cyc(1'b0, 1'b1, 2'd2, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R9 bit1 set wins", host_rdata, 16'hF0F2);
    // R9: coprocessor sets bit0 while host clears it
    cyc(1'b0, 1'b1, 2'd2, 16'h0, 1'b1, 1'b0, 1'b0, 16'h1111);
    chk("R9 host pre-read", host_rdata, 16'hF0F2);
    cyc(1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 1'b1, 16'h0);
    chk("R9 bit0 set wins", cp_rdata, 16'hF0F3);
    cyc(1'b0, 1'b1, 2'd0, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R5 status 1111", host_rdata, 16'h1111);
    // flags now F0F1

    // R11: both write the status word together
    cyc(1'b1, 1'b0, 2'd0, 16'h2222, 1'b1, 1'b0, 1'b0, 16'h3333);
    cyc(1'b0, 1'b1, 2'd0, 16'h0, 1'b0, 1'b1, 1'b0, 16'h0);
    chk("R11 host value kept", host_rdata, 16'h2222);
    chk("R11 cp sees host value", cp_rdata, 16'h2222);
    cyc(1'b0, 1'b1, 2'd2, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R11 both flags", host_rdata, 16'hF0F3);

    // R12: read data holds over idle cycles
    repeat (4) @(negedge clk);
    chk("R12 host hold", host_rdata, 16'hF0F3);
    chk("R12 cp hold", cp_rdata, 16'h2222);

    // R13: flag load with same-cycle host set
    cyc(1'b1, 1'b0, 2'd1, 16'h4444, 1'b1, 1'b0, 1'b1, 16'h0000);
    cyc(1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 1'b1, 16'h0);
    chk("R13 set ORed into load", cp_rdata, 16'h0002);
    // R13: flag load overrides same-cycle host clear
    cyc(1'b0, 1'b1, 2'd2, 16'h0, 1'b1, 1'b0, 1'b1, 16'h0001);
    chk("R13 host pre-read", host_rdata, 16'h0000);
    cyc(1'b0, 1'b1, 2'd2, 16'h0, 1'b0, 1'b0, 1'b0, 16'h0);
    chk("R13 clear skipped", host_rdata, 16'h0001);

    // R1: reset in mid-run
    cyc(1'b1, 1'b0, 2'd0, 16'h9999, 1'b0, 1'b0, 1'b0, 16'h0);
    cyc(1'b0, 1'b1, 2'd0, 16'h0, 1'b0, 1'b1, 1'b0, 16'h0);
    chk("R2 pre-reset status", host_rdata, 16'h9999);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 host_rdata cleared", host_rdata, 16'h0000);
    chk("R1 cp_rdata cleared", cp_rdata, 16'h0000);
    cyc(1'b0, 1'b1, 2'd0, 16'h0, 1'b0, 1'b1, 1'b1, 16'h0);
    chk("R1 status cleared", host_rdata, 16'h0000);
    chk("R1 flags cleared", cp_rdata, 16'h0000);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule